// File: doc/BRIEF.md
# Pipelined 128-bit Parallel CRC Engine

This block folds a full 128-bit data word into a running CRC on every clock cycle. The next-state function of a CRC is linear. It therefore splits into two parts. One part depends only on the incoming word. The other depends only on the current CRC register. The data part does not feed back, so it is computed and registered in a delay pipeline of `DATA_STAGES` stages. Only the state part, a 32-input XOR tree behind a start-of-frame multiplexer, is left inside the one-cycle recurrence. The valid, start and end flags travel through the same pipeline, so they stay aligned with the precomputed data terms.

A small controller tracks whether a frame is open. It has two states. `ST_IDLE` means no frame is open. `ST_ACCUM` means a frame is being accumulated. The transitions are:
- `ST_IDLE` to `ST_ACCUM` when an aligned valid start word arrives that is not also an end word.
- `ST_ACCUM` to `ST_IDLE` when an aligned valid end word arrives.
- Every other case holds the state. A start word inside an open frame restarts the frame and stays in `ST_ACCUM`.

When a frame closes, the inverted CRC is registered onto `crc_out`, and `crc_valid` pulses for one cycle.

Top module: `crc128_pipe`

## Requirements
- R1: While `rst_n` is low, and afterwards until the first result, `crc_valid` is 0 and `crc_out` is 0.
- R2: The CRC is non-reflected with polynomial `POLY` (default 0x04C11DB7). Bit 127 of `in_data` is processed first, then down to bit 0. The register is loaded with all ones at start of frame, and the reported result is the final register inverted (XOR with all ones).
- R3: One 128-bit word is absorbed per cycle. Back-to-back frames with no idle cycle between them each give the correct result.
- R4: `crc_valid` is high for exactly one cycle, beginning after the `DATA_STAGES`-th rising edge (default 2) following the edge that samples the end-of-frame word. `crc_out` holds that result until the next result.
- R5: Cycles with `in_valid` low inside an open frame leave the CRC unchanged, so gaps do not alter the result.
- R6: A word with `in_valid` high that arrives outside an open frame without `in_sof` is ignored, including an end-only word. It produces no result.
- R7: A start word arriving inside an open frame discards the partial CRC and restarts from the initial value.
- R8: A single-word frame, with `in_sof` and `in_eof` on the same word, gives the CRC of that word alone.
- R9: For random frames of 1 to 16 words, every result equals a bit-serial CRC computed under R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word qualifier |
| in_sof | input | 1 | First word of a frame (meaningful with in_valid) |
| in_eof | input | 1 | Last word of a frame (meaningful with in_valid) |
| in_data | input | 128 | Data word, bit 127 processed first |
| crc_valid | output | 1 | One-cycle pulse marking a new result |
| crc_out | output | 32 | Inverted CRC of the last completed frame |

## Verification
The end word is sampled at edge E. The first pipeline register captures its data term at E, and the term reaches the last stage `DATA_STAGES`-1 edges later. It is folded into the CRC at edge E+`DATA_STAGES`, and the result register is written at that same edge. The bench numbers every rising edge. For each closing word it stores the expected value together with its due edge number. A monitor at the falling edge compares both the value and the edge number whenever `crc_valid` is high, and reports any pulse for which no result is pending. Each scenario ends by waiting `DATA_STAGES`+3 cycles and then checks that no expected result is still outstanding, which also covers results that never appear.

// File: rtl/crc128_pkg.sv
package crc128_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ACCUM = 1'b1
    } crc_fsm_e;

endpackage

// File: rtl/crc_data_pipe.sv
module crc_data_pipe #(
    parameter int              DATA_W = 128,
    parameter int              CRC_W  = 32,
    parameter logic [CRC_W-1:0] POLY  = 32'h04C11DB7,
    parameter int              STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [DATA_W-1:0] in_data,
    output logic              al_vld,
    output logic              al_sof,
    output logic              al_eof,
    output logic [CRC_W-1:0]  al_term
);

    // Contribution of a data word to the CRC with the register taken as zero.
    function automatic logic [CRC_W-1:0] data_term(input logic [DATA_W-1:0] d);
        logic [CRC_W-1:0] s;
        logic             fb;
        s = '0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb = s[CRC_W-1] ^ d[i];
            s  = {s[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
        return s;
    endfunction

    logic [CRC_W-1:0] term_q [STAGES];
    logic             vld_q  [STAGES];
    logic             sof_q  [STAGES];
    logic             eof_q  [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            term_q[0] <= '0;
            vld_q[0]  <= 1'b0;
            sof_q[0]  <= 1'b0;
            eof_q[0]  <= 1'b0;
        end else begin
            term_q[0] <= data_term(in_data);
            vld_q[0]  <= in_vld;
            sof_q[0]  <= in_vld & in_sof;
            eof_q[0]  <= in_vld & in_eof;
        end
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_delay
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                term_q[g] <= '0;
                vld_q[g]  <= 1'b0;
                sof_q[g]  <= 1'b0;
                eof_q[g]  <= 1'b0;
            end else begin
                term_q[g] <= term_q[g-1];
                vld_q[g]  <= vld_q[g-1];
                sof_q[g]  <= sof_q[g-1];
                eof_q[g]  <= eof_q[g-1];
            end
        end
    end

    assign al_vld  = vld_q[STAGES-1];
    assign al_sof  = sof_q[STAGES-1];
    assign al_eof  = eof_q[STAGES-1];
    assign al_term = term_q[STAGES-1];

    // R6: an idle input cycle never creates a valid entry in the pipe.
    p_no_phantom_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !vld_q[0]);

    // R4: the flag pair leaving the pipe never carries sof/eof without valid.
    p_flags_qualified_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (al_sof | al_eof) |-> al_vld);

endmodule

// File: rtl/crc_state_loop.sv
module crc_state_loop
    import crc128_pkg::*;
#(
    parameter int               DATA_W = 128,
    parameter int               CRC_W  = 32,
    parameter logic [CRC_W-1:0] POLY   = 32'h04C11DB7,
    parameter logic [CRC_W-1:0] INIT   = '1,
    parameter logic [CRC_W-1:0] XOROUT = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             al_vld,
    input  logic             al_sof,
    input  logic             al_eof,
    input  logic [CRC_W-1:0] al_term,
    output logic             crc_vld_o,
    output logic [CRC_W-1:0] crc_o
);

    // Contribution of the register after shifting DATA_W zero bits.
    function automatic logic [CRC_W-1:0] state_term(input logic [CRC_W-1:0] c);
        logic [CRC_W-1:0] s;
        s = c;
        for (int i = 0; i < DATA_W; i++) begin
            s = {s[CRC_W-2:0], 1'b0} ^ (s[CRC_W-1] ? POLY : '0);
        end
        return s;
    endfunction

    localparam logic [CRC_W-1:0] INIT_TERM = state_term(INIT);

    crc_fsm_e         st_q, st_d;
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] next_crc;
    logic             accept;
    logic             close;

    always_comb begin
        next_crc = (al_sof ? INIT_TERM : state_term(crc_q)) ^ al_term;
        accept   = al_vld && (al_sof || st_q == ST_ACCUM);
        close    = accept && al_eof;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (al_vld && al_sof && !al_eof) st_d = ST_ACCUM;
            ST_ACCUM: if (al_vld && al_eof)            st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // State register process.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            crc_q <= INIT;
        end else begin
            st_q  <= st_d;
            if (accept) crc_q <= next_crc;
        end
    end

    // Output process.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_vld_o <= 1'b0;
            crc_o     <= '0;
        end else begin
            crc_vld_o <= close;
            if (close) crc_o <= next_crc ^ XOROUT;
        end
    end

    // R5: without an aligned word neither the register nor the result moves.
    p_hold_on_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !al_vld |=> ($stable(crc_q) && $stable(crc_o)));

    // R4: a result pulse only follows an aligned end word.
    p_result_after_eof_r4: assert property (@(posedge clk) disable iff (!rst_n)
        crc_vld_o |-> $past(al_eof));

    // R7: a start word that is not an end word leaves a frame open.
    p_open_on_sof_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (al_vld && al_sof && !al_eof) |=> (st_q == ST_ACCUM));

    // R3: an aligned end word always closes the frame.
    p_close_on_eof_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (al_vld && al_eof) |=> (st_q == ST_IDLE));

endmodule

// File: rtl/crc128_pipe.sv
module crc128_pipe #(
    parameter int               DATA_W      = 128,
    parameter int               CRC_W       = 32,
    parameter logic [CRC_W-1:0] POLY        = 32'h04C11DB7,
    parameter logic [CRC_W-1:0] INIT        = '1,
    parameter logic [CRC_W-1:0] XOROUT      = '1,
    parameter int               DATA_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [DATA_W-1:0] in_data,
    output logic              crc_valid,
    output logic [CRC_W-1:0]  crc_out
);

    logic             al_vld, al_sof, al_eof;
    logic [CRC_W-1:0] al_term;

    crc_data_pipe #(
        .DATA_W (DATA_W),
        .CRC_W  (CRC_W),
        .POLY   (POLY),
        .STAGES (DATA_STAGES)
    ) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (in_valid),
        .in_sof  (in_sof),
        .in_eof  (in_eof),
        .in_data (in_data),
        .al_vld  (al_vld),
        .al_sof  (al_sof),
        .al_eof  (al_eof),
        .al_term (al_term)
    );

    crc_state_loop #(
        .DATA_W (DATA_W),
        .CRC_W  (CRC_W),
        .POLY   (POLY),
        .INIT   (INIT),
        .XOROUT (XOROUT)
    ) u_loop (
        .clk       (clk),
        .rst_n     (rst_n),
        .al_vld    (al_vld),
        .al_sof    (al_sof),
        .al_eof    (al_eof),
        .al_term   (al_term),
        .crc_vld_o (crc_valid),
        .crc_o     (crc_out)
    );

    // R1: no result can be reported while reset is held.
    p_quiet_in_reset_r1: assert property (@(posedge clk)
        !rst_n |=> !crc_valid);

endmodule

// File: tb/crc128_pipe_test.sv
`timescale 1ns/1ps
module crc128_pipe_test;

    localparam int STG = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_sof = 1'b0;
    logic         in_eof = 1'b0;
    logic [127:0] in_data = '0;
    logic         crc_valid;
    logic [31:0]  crc_out;

    crc128_pipe #(.DATA_STAGES(STG)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_eof    (in_eof),
        .in_data   (in_data),
        .crc_valid (crc_valid),
        .crc_out   (crc_out)
    );

    always #2 clk = ~clk;

    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc   = 0;
    bit          done  = 1'b0;
    string       cur_tag = "R2";

    logic [31:0] exp_crc [256];
    int          exp_due [256];
    string       exp_tag [256];
    logic [7:0]  head = '0;
    logic [7:0]  tail = '0;
    logic [31:0] ref_crc = '1;
    bit          ref_open = 1'b0;
    logic [31:0] last_res = '0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] ser_step(input logic [31:0] c, input logic [127:0] d);
        logic [31:0] s;
        logic        fb;
        s = c;
        for (int i = 127; i >= 0; i--) begin
            fb = s[31] ^ d[i];
            s  = {s[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
        end
        return s;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Monitor: value and due edge of each result.
    always @(negedge clk) begin
        if (rst_n && crc_valid) begin
            if (head == tail) begin
                check(1'b0, "R6", "unexpected result", crc_out, 32'h0);
            end else begin
                check(crc_out === exp_crc[head], exp_tag[head], "crc value",
                      crc_out, exp_crc[head]);
                check(cyc == exp_due[head], "R4", "result edge",
                      cyc, exp_due[head]);
                last_res = exp_crc[head];
                head = head + 1;
            end
        end
    end

    // One call = one cycle; called at a falling edge.
    task automatic drive(input bit v, input bit s, input bit e, input logic [127:0] d);
        in_valid = v;
        in_sof   = s;
        in_eof   = e;
        in_data  = d;
        if (v && (s || ref_open)) begin
            if (s) ref_crc = 32'hFFFFFFFF;
            ref_crc  = ser_step(ref_crc, d);
            ref_open = !e;
            if (e) begin
                exp_crc[tail] = ~ref_crc;
                exp_due[tail] = cyc + 1 + STG;
                exp_tag[tail] = cur_tag;
                tail = tail + 1;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_eof   = 1'b0;
    endtask

    task automatic drain(input string tag);
        repeat (STG + 3) @(negedge clk);
        check(head == tail, tag, "results outstanding", 32'(tail - head), 32'h0);
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic t_reset();
        check(crc_valid === 1'b0, "R1", "crc_valid in reset", 32'(crc_valid), 32'h0);
        check(crc_out === 32'h0, "R1", "crc_out in reset", crc_out, 32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(crc_valid === 1'b0, "R1", "crc_valid after reset", 32'(crc_valid), 32'h0);
        check(crc_out === 32'h0, "R1", "crc_out after reset", crc_out, 32'h0);
    endtask

    task automatic t_single();
        cur_tag = "R8";
        drive(1, 1, 1, 128'h0);
        drive(1, 1, 1, {128{1'b1}});
        drive(1, 1, 1, 128'h0123456789ABCDEF_FEDCBA9876543210);
        drain("R8");
    endtask

    task automatic t_hold();
        cur_tag = "R4";
        drive(1, 1, 0, 128'h1);
        drive(1, 0, 1, 128'h80000000_00000000_00000000_00000000);
        drain("R4");
        repeat (4) @(negedge clk);
        check(crc_valid === 1'b0, "R4", "pulse length", 32'(crc_valid), 32'h0);
        check(crc_out === last_res, "R4", "result held", crc_out, last_res);
    endtask

    task automatic t_b2b();
        cur_tag = "R3";
        drive(1, 1, 0, rnd128());
        drive(1, 0, 1, rnd128());
        drive(1, 1, 1, rnd128());
        drive(1, 1, 0, rnd128());
        drive(1, 0, 0, rnd128());
        drive(1, 0, 1, rnd128());
        drive(1, 1, 1, rnd128());
        drain("R3");
    endtask

    task automatic t_gaps();
        cur_tag = "R5";
        drive(1, 1, 0, rnd128());
        drive(0, 0, 0, rnd128());
        drive(0, 1, 1, rnd128());
        drive(1, 0, 0, rnd128());
        repeat (3) drive(0, 0, 1, rnd128());
        drive(1, 0, 1, rnd128());
        drain("R5");
    endtask

    task automatic t_orphan();
        cur_tag = "R6";
        drive(1, 0, 0, rnd128());
        drive(1, 0, 1, rnd128());
        drive(1, 0, 1, rnd128());
        drain("R6");
        check(crc_out === last_res, "R6", "output untouched", crc_out, last_res);
        drive(1, 1, 0, rnd128());
        drive(1, 0, 1, rnd128());
        drain("R6");
    endtask

    task automatic t_restart();
        cur_tag = "R7";
        drive(1, 1, 0, rnd128());
        drive(1, 0, 0, rnd128());
        drive(1, 1, 0, rnd128());
        drive(1, 0, 1, rnd128());
        drain("R7");
    endtask

    task automatic t_random();
        cur_tag = "R9";
        for (int f = 0; f < 40; f++) begin
            int len;
            len = 1 + int'($urandom % 16);
            for (int w = 0; w < len; w++) begin
                if ($urandom % 4 == 0) drive(0, 0, 0, rnd128());
                drive(1, w == 0, w == len - 1, rnd128());
            end
        end
        drain("R9");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        t_single();
        t_hold();
        t_b2b();
        t_gaps();
        t_orphan();
        t_restart();
        t_random();
        finish_run();
    end

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

endmodule